// File: doc/BRIEF.md
# Snooped Cache Control Register Decoder

This block listens to processor bus write cycles addressed to the register space of an on-board video controller and keeps its own copy of two control bits from those writes. The copies drive two active-low outputs to an external cache card: one enables the cache and one requests a flush. The block never answers a bus cycle. It never drives the data bus and it never changes the video controller.

All bus inputs are asynchronous to the block clock. They are brought in through a two-flop synchronizer. A control module then looks for the first clock of each bus cycle that hits the decoded register. On that clock it issues a one-cycle load strobe to a datapath module, which holds the two output registers.

Top module: `cache_ctl_snoop`

## Requirements
- R1: A write is decoded when the address strobe, the video select and the read/write line are all low and address bits 0, 1 and 4 are all low. Address bits 2, 3, 5, 6 and 7 take no part in the decode.
- R2: On a decoded write, `cacheEnN` takes the value of data bit 0, so writing 0 drives it low and writing 1 drives it high. The other data bits have no effect on it.
- R3: On a decoded write, `cacheFlushN` takes the value of data bit 3, so writing 0 drives it low and writing 1 drives it high.
- R4: While `rst` is high at a rising clock edge, both outputs become high. `rst` wins over a decoded write on the same edge.
- R5: The outputs keep their values in these cases: a read cycle, a cycle with the video select high, a cycle with address bit 0, 1 or 4 high, and a cycle with the strobe high.
- R6: A decoded write updates the outputs only once per bus cycle. A data change later in the same strobe-low cycle is ignored.
- R7: Inputs that change just after a rising edge reach the outputs on the third rising edge after that change: two synchronizer stages and then the output register.
- R8: If `rst` is released while a decoded write cycle is still in progress, that cycle causes no update. Only the next bus cycle can load the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| busStrobeN | input | 1 | Address strobe, active low, asynchronous |
| vidSelN | input | 1 | Video controller select, active low, asynchronous |
| rdWrN | input | 1 | High for read, low for write |
| addrIn | input | 8 | Low address bits of the bus |
| dataIn | input | 8 | Low data byte of the bus |
| cacheEnN | output | 1 | Cache enable, active low, registered |
| cacheFlushN | output | 1 | Cache flush request, active low, registered |

## Verification
The bench drives bus inputs on falling edges. Any decoded write therefore reaches the outputs on the third rising edge after it is driven: two synchronizer stages and one output register. The plain checks wait four falling edges before they record an expected value.

The latency test records the old value two falling edges after the drive and the new value one falling edge later. This pins down the exact edge on which the output changes. A monitor compares every queued expectation against the outputs 1 ns after it is posted, well away from any rising edge.

// File: rtl/cache_snoop_pkg.sv
package cache_snoop_pkg;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic clear;  // force both outputs inactive
    logic load;   // capture the synchronized data bits
  } ctlStrobe_t;

endpackage

// File: rtl/cache_snoop_sync.sv
module cache_snoop_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  // No reset on the chain: it always mirrors the bus, so a reset release
  // never produces a false edge on a bus cycle that is still in progress.
  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) stageQ[s] <= asyncIn;
      end else begin : g_next
        always_ff @(posedge clk) stageQ[s] <= stageQ[s-1];
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/cache_snoop_ctrl.sv
module cache_snoop_ctrl
  import cache_snoop_pkg::*;
#(
  parameter int               ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] DECODE_MASK = 8'h13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobeN,
  input  logic              selectN,
  input  logic              rdWrN,
  input  logic [ADDR_W-1:0] addr,
  output ctlStrobe_t        strobes
);

  logic addrHit;
  logic cycleHit;
  logic hitPrev;

  assign addrHit  = ((addr & DECODE_MASK) == '0);
  assign cycleHit = !strobeN && !selectN && !rdWrN && addrHit;

  // Tracks the hit through reset as well, so a cycle that spans a reset
  // release is treated as already seen.
  always_ff @(posedge clk) hitPrev <= cycleHit;

  always_comb begin
    strobes.clear = rst;
    strobes.load  = cycleHit && !hitPrev && !rst;
  end

  // R6: one load per bus cycle
  a_r6_single_load : assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> !strobes.load);

  // R5: masked address bit set never loads
  a_r5_addr_reject : assert property (@(posedge clk) disable iff (rst)
    ((addr & DECODE_MASK) != '0) |-> !strobes.load);

  // R1: read cycles and deselected cycles never load
  a_r1_write_select : assert property (@(posedge clk) disable iff (rst)
    (rdWrN || selectN || strobeN) |-> !strobes.load);

endmodule

// File: rtl/cache_snoop_dpath.sv
module cache_snoop_dpath
  import cache_snoop_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int EN_BIT    = 0,
  parameter int FLUSH_BIT = 3
) (
  input  logic              clk,
  input  ctlStrobe_t        strobes,
  input  logic [DATA_W-1:0] dataIn,
  output logic              enN,
  output logic              flushN
);

  localparam logic [DATA_W-1:0] KEEP_MASK =
    (DATA_W'(1) << EN_BIT) | (DATA_W'(1) << FLUSH_BIT);

  logic [DATA_W-1:0] keptBits;
  assign keptBits = dataIn & KEEP_MASK;

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      enN    <= 1'b1;
      flushN <= 1'b1;
    end else if (strobes.load) begin
      enN    <= keptBits[EN_BIT];
      flushN <= keptBits[FLUSH_BIT];
    end
  end

  // R4: outputs inactive right after reset
  a_r4_reset_inactive : assert property (@(posedge clk) disable iff (strobes.clear)
    $fell(strobes.clear) |-> (enN && flushN));

  // R2: enable follows its data bit
  a_r2_enable_follows : assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.load |=> (enN == $past(dataIn[EN_BIT])));

  // R3: flush follows its data bit
  a_r3_flush_follows : assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.load |=> (flushN == $past(dataIn[FLUSH_BIT])));

  // R5: no load, no change
  a_r5_hold : assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.load |=> ($stable(enN) && $stable(flushN)));

endmodule

// File: rtl/cache_ctl_snoop.sv
module cache_ctl_snoop
  import cache_snoop_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int EN_BIT    = 0,
  parameter int FLUSH_BIT = 3,
  parameter int SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busStrobeN,
  input  logic              vidSelN,
  input  logic              rdWrN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              cacheEnN,
  output logic              cacheFlushN
);

  localparam int SYNC_W = 3 + ADDR_W + DATA_W;
  // Address bits 0, 1 and 4 take part in the decode.
  localparam logic [ADDR_W-1:0] DECODE_MASK =
    (ADDR_W'(1) << 0) | (ADDR_W'(1) << 1) | (ADDR_W'(1) << 4);

  logic [SYNC_W-1:0] rawBus;
  logic [SYNC_W-1:0] syncBus;
  logic              strobeS, selectS, rdWrS;
  logic [ADDR_W-1:0] addrS;
  logic [DATA_W-1:0] dataS;
  ctlStrobe_t        strobes;

  assign rawBus = {busStrobeN, vidSelN, rdWrN, addrIn, dataIn};
  assign {strobeS, selectS, rdWrS, addrS, dataS} = syncBus;

  cache_snoop_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_LEN)) sync_i (
    .clk     (clk),
    .asyncIn (rawBus),
    .syncOut (syncBus)
  );

  cache_snoop_ctrl #(.ADDR_W(ADDR_W), .DECODE_MASK(DECODE_MASK)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .strobeN (strobeS),
    .selectN (selectS),
    .rdWrN   (rdWrS),
    .addr    (addrS),
    .strobes (strobes)
  );

  cache_snoop_dpath #(.DATA_W(DATA_W), .EN_BIT(EN_BIT), .FLUSH_BIT(FLUSH_BIT)) dpath_i (
    .clk     (clk),
    .strobes (strobes),
    .dataIn  (dataS),
    .enN     (cacheEnN),
    .flushN  (cacheFlushN)
  );

endmodule

// File: tb/cache_ctl_snoop_tb_top.sv
`timescale 1ns/1ps
module cache_ctl_snoop_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       busStrobeN = 1'b1;
  logic       vidSelN = 1'b1;
  logic       rdWrN = 1'b1;
  logic [7:0] addrIn = 8'h00;
  logic [7:0] dataIn = 8'h00;
  logic       cacheEnN;
  logic       cacheFlushN;

  always #2 clk = ~clk;

  cache_ctl_snoop dut_i (
    .clk         (clk),
    .rst         (rst),
    .busStrobeN  (busStrobeN),
    .vidSelN     (vidSelN),
    .rdWrN       (rdWrN),
    .addrIn      (addrIn),
    .dataIn      (dataIn),
    .cacheEnN    (cacheEnN),
    .cacheFlushN (cacheFlushN)
  );

  typedef struct {
    logic  en;
    logic  fl;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int   checks = 0;
  int   errors = 0;
  logic expEn = 1'b1;
  logic expFl = 1'b1;
  bit   finished = 1'b0;

  // Monitor: compare each expectation 1 ns after it is posted.
  initial begin
    forever begin
      expItem_t item;
      wait (expQ.size() != 0);
      item = expQ.pop_front();
      #1;
      checks++;
      if (cacheEnN !== item.en || cacheFlushN !== item.fl) begin
        errors++;
        $display("FAIL %s: actual en=%b flush=%b expected en=%b flush=%b",
                 item.tag, cacheEnN, cacheFlushN, item.en, item.fl);
      end
    end
  end

  task automatic expectNow(input string tag);
    expItem_t item;
    item.en = expEn; item.fl = expFl; item.tag = tag;
    expQ.push_back(item);
    #2;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic driveBus(input logic stb, input logic sel, input logic rw,
                          input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busStrobeN = stb; vidSelN = sel; rdWrN = rw; addrIn = a; dataIn = d;
  endtask

  task automatic idleBus();
    driveBus(1'b1, 1'b1, 1'b1, 8'h00, 8'h00);
  endtask

  // One complete bus cycle followed by idle; checks during and after.
  task automatic busCycle(input logic stb, input logic sel, input logic rw,
                          input logic [7:0] a, input logic [7:0] d,
                          input bit decodes, input string tag);
    driveBus(stb, sel, rw, a, d);
    settle(4);
    if (decodes) begin expEn = d[0]; expFl = d[3]; end
    expectNow(tag);
    idleBus();
    settle(3);
    expectNow(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R4: reset state
    settle(4);
    expectNow("R4 reset state");
    @(negedge clk) rst = 1'b0;
    settle(2);

    // R2 and R3: each data combination at register 0
    busCycle(0, 0, 0, 8'h00, 8'h00, 1, "R2 R3 data 00");
    busCycle(0, 0, 0, 8'h00, 8'h01, 1, "R2 R3 data 01");
    busCycle(0, 0, 0, 8'h00, 8'h08, 1, "R2 R3 data 08");
    busCycle(0, 0, 0, 8'h00, 8'h09, 1, "R2 R3 data 09");
    busCycle(0, 0, 0, 8'h00, 8'hF6, 1, "R2 other data bits F6");

    // R1: address bits 2, 3 and upper bits do not block the decode
    busCycle(0, 0, 0, 8'h04, 8'h09, 1, "R1 addr 04");
    busCycle(0, 0, 0, 8'h0C, 8'h00, 1, "R1 addr 0C");
    busCycle(0, 0, 0, 8'hE8, 8'h09, 1, "R1 addr E8");

    // R5: cycles that must be ignored (state is high/high)
    busCycle(0, 0, 0, 8'h01, 8'h00, 0, "R5 addr bit0 set");
    busCycle(0, 0, 0, 8'h02, 8'h00, 0, "R5 addr bit1 set");
    busCycle(0, 0, 0, 8'h10, 8'h00, 0, "R5 addr bit4 set");
    busCycle(0, 0, 1, 8'h00, 8'h00, 0, "R5 read cycle");
    busCycle(0, 1, 0, 8'h00, 8'h00, 0, "R5 select high");
    busCycle(1, 0, 0, 8'h00, 8'h00, 0, "R5 strobe high");

    // R7: exact latency, from high/high to low/high
    driveBus(0, 0, 0, 8'h00, 8'h08);
    settle(2);
    expectNow("R7 before third edge");
    settle(1);
    expEn = 1'b0; expFl = 1'b1;
    expectNow("R7 at third edge");
    idleBus();
    settle(3);

    // R6: long cycle, data changes mid-cycle is ignored
    driveBus(0, 0, 0, 8'h00, 8'h01);
    settle(4);
    expEn = 1'b1; expFl = 1'b0;
    expectNow("R6 first capture");
    dataIn = 8'h08;
    settle(5);
    expectNow("R6 mid-cycle data change ignored");
    idleBus();
    settle(3);
    expectNow("R6 after long cycle");

    // R4 and R8: reset during a write that would drive both low
    busCycle(0, 0, 0, 8'h00, 8'h09, 1, "R4 setup high");
    driveBus(0, 0, 0, 8'h00, 8'h00);
    settle(1);
    rst = 1'b1;
    settle(4);
    expectNow("R4 reset beats write");
    rst = 1'b0;
    settle(5);
    expectNow("R8 held cycle after reset ignored");
    idleBus();
    settle(3);
    busCycle(0, 0, 0, 8'h00, 8'h00, 1, "R8 next cycle loads");

    wait (expQ.size() == 0);
    #3;
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule